// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one down-counting timer channel reached through a pair of byte-wide ports: a command port that takes a control word and a data port that moves the 16-bit count. Writing a control word picks how the count bytes are transferred (low byte only, high byte only, or low then high) and which of two counting behaviours runs. The first behaviour raises the output once when the count runs out. The second is a periodic divider that drops the output for one count period in every cycle of reload value periods.

Counting advances on a separate slow count-enable strobe, not on every clock. Software can freeze a snapshot of the running count with a latch command and then read it back a byte at a time while the counter keeps moving. Without a latch, data-port reads return the live count.

Top module: `pit_channel`

## Requirements
- R1: A command-port write (`port_sel`=1) is a control word. Bits 7:6 pick the counter, and only 00 is served. Bits 5:4 give the transfer mode: 00 latch, 01 low byte only, 10 high byte only, 11 low then high. Bits 3:1 give the behaviour: 000 one-shot, 010 periodic. Bit 0 set asks for decimal counting. A word with counter other than 00, with bit 0 set, or with any other behaviour code changes nothing: count, output and mode stay as they were.
- R2: In transfer mode 11, a reload is two data-port writes (`port_sel`=0), low byte then high byte, and the count takes the value once the high byte is in. A new control word sends the next write back to the low byte.
- R3: In transfer mode 01 or 10, one data write loads the count, with the other byte cleared. Each read returns only that byte, and a latched value is released after that single read.
- R4: After a non-latch control word the count stays frozen until the reload is complete. After that, each count-enable pulse lowers it by one.
- R5: In one-shot mode the output is low after the control word and after a load. It rises when the count reaches 0 and then stays high, while the count wraps from 0 to 0xFFFF.
- R6: In periodic mode the output is high after the control word. It is low only while the count is 1, and the next enable pulse reloads the count and raises the output, so the period is the reload value in enable pulses.
- R7: A latch command (control word 0x00) captures the count. Reads then return the snapshot, low byte then high byte in mode 11, and counting continues meanwhile. The snapshot is released after its last byte is read.
- R8: A latch command issued while a snapshot is still held is ignored.
- R9: A latch command in the same cycle as a count-enable pulse captures the value before that decrement.
- R10: With no snapshot held, reads return the live count, alternating low and high bytes in mode 11.
- R11: After reset the output is high, `rdata` is 0, the count is 0 and counting is stopped.
- R12: `rdata` is registered. It changes only on the clock edge that accepts a data-port read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | One-cycle count-enable strobe |
| wr_en | input | 1 | Port write strobe |
| rd_en | input | 1 | Port read strobe |
| port_sel | input | 1 | 1 = command port, 0 = data port |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, registered |
| tmr_out | output | 1 | Timer output |

## Verification
The latch command and a count-enable pulse can land on the same clock edge. This is provoked by raising `cnt_en` in the very cycle the command-port write of 0x00 is presented. The check is that the snapshot then read back equals the count before the decrement, while a second latch taken afterwards shows the decremented value. A latch command arriving while an earlier snapshot is still unread is also provoked between count pulses, and the check is that the older value is the one read out.

// File: rtl/pit_pkg.sv
package pit_pkg;
  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_WORD  = 2'b11
  } acc_e;

  localparam logic [2:0] OPM_ONESHOT = 3'b000;
  localparam logic [2:0] OPM_PERIOD  = 3'b010;
endpackage

// File: rtl/pit_cmd_decode.sv
module pit_cmd_decode
  import pit_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              port_sel,
  input  logic [BYTE_W-1:0] wdata,
  output logic              latch_req,
  output logic              cfg_pulse,
  output logic              load_pulse,
  output acc_e              acc_mode,
  output logic              period_mode,
  output logic [CNT_W-1:0]  reload_val
);
  logic              wr_cmd, wr_dat;
  logic              sel_ok, opm_ok;
  logic              hi_next;
  logic [BYTE_W-1:0] lo_hold;

  assign wr_cmd = wr_en & port_sel;
  assign wr_dat = wr_en & ~port_sel;
  assign sel_ok = (wdata[7:6] == 2'b00);
  assign opm_ok = (wdata[3:1] == OPM_ONESHOT) || (wdata[3:1] == OPM_PERIOD);

  // latch is combinational so it samples the count on the command edge
  assign latch_req = wr_cmd && sel_ok && (wdata[5:4] == 2'b00);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_pulse   <= 1'b0;
      load_pulse  <= 1'b0;
      acc_mode    <= ACC_WORD;
      period_mode <= 1'b0;
      reload_val  <= '0;
      lo_hold     <= '0;
      hi_next     <= 1'b0;
    end else begin
      cfg_pulse  <= 1'b0;
      load_pulse <= 1'b0;
      if (wr_cmd && sel_ok && (wdata[5:4] != 2'b00) && !wdata[0] && opm_ok) begin
        cfg_pulse   <= 1'b1;
        acc_mode    <= acc_e'(wdata[5:4]);
        period_mode <= (wdata[3:1] == OPM_PERIOD);
        hi_next     <= 1'b0;
      end else if (wr_dat) begin
        unique case (acc_mode)
          ACC_LO: begin
            reload_val <= {{BYTE_W{1'b0}}, wdata};
            load_pulse <= 1'b1;
          end
          ACC_HI: begin
            reload_val <= {wdata, {BYTE_W{1'b0}}};
            load_pulse <= 1'b1;
          end
          default: begin
            if (hi_next) begin
              reload_val <= {wdata, lo_hold};
              load_pulse <= 1'b1;
              hi_next    <= 1'b0;
            end else begin
              lo_hold <= wdata;
              hi_next <= 1'b1;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/pit_down_counter.sv
module pit_down_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic             cfg_pulse,
  input  logic             load_pulse,
  input  logic             period_mode,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count_q,
  output logic             running,
  output logic             tmr_out
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] dec_val;
  assign dec_val = count_q - ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      running <= 1'b0;
      tmr_out <= 1'b1;
    end else if (cfg_pulse) begin
      running <= 1'b0;
      tmr_out <= period_mode;
    end else if (load_pulse) begin
      count_q <= reload_val;
      running <= 1'b1;
      tmr_out <= period_mode;
    end else if (running && cnt_en) begin
      if (period_mode) begin
        if (count_q == ONE) begin
          count_q <= reload_val;
          tmr_out <= 1'b1;
        end else begin
          count_q <= dec_val;
          tmr_out <= (dec_val != ONE);
        end
      end else begin
        count_q <= dec_val;
        if (dec_val == '0) tmr_out <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pit_latch_rd.sv
module pit_latch_rd
  import pit_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_pulse,
  input  logic              latch_req,
  input  logic              rd_pulse,
  input  acc_e              acc_mode,
  input  logic [CNT_W-1:0]  count_q,
  output logic              held,
  output logic [CNT_W-1:0]  snap,
  output logic [BYTE_W-1:0] rdata
);
  logic [CNT_W-1:0]  src;
  logic [BYTE_W-1:0] src_byte [2];
  logic [BYTE_W-1:0] pick;
  logic              rd_hi;

  assign src = held ? snap : count_q;

  for (genvar g = 0; g < 2; g++) begin : g_byte
    assign src_byte[g] = src[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    unique case (acc_mode)
      ACC_LO:  pick = src_byte[0];
      ACC_HI:  pick = src_byte[1];
      default: pick = rd_hi ? src_byte[1] : src_byte[0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held  <= 1'b0;
      snap  <= '0;
      rd_hi <= 1'b0;
      rdata <= '0;
    end else if (cfg_pulse) begin
      held  <= 1'b0;
      rd_hi <= 1'b0;
    end else begin
      if (rd_pulse) begin
        rdata <= pick;
        if (acc_mode == ACC_WORD) rd_hi <= ~rd_hi;
        if (held && ((acc_mode != ACC_WORD) || rd_hi)) held <= 1'b0;
      end
      if (latch_req && !held) begin
        held <= 1'b1;
        snap <= count_q;
      end
    end
  end
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              port_sel,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              tmr_out
);
  logic             latch_req, cfg_strobe, load_pulse, rate_mode;
  logic             running, latch_held, rd_pulse;
  logic [CNT_W-1:0] reload_val, cur_count, snap;
  acc_e             acc_mode;

  assign rd_pulse = rd_en & ~port_sel;

  pit_cmd_decode #(.BYTE_W(BYTE_W)) u_dec (
    .clk(clk), .rst(rst), .wr_en(wr_en), .port_sel(port_sel), .wdata(wdata),
    .latch_req(latch_req), .cfg_pulse(cfg_strobe), .load_pulse(load_pulse),
    .acc_mode(acc_mode), .period_mode(rate_mode), .reload_val(reload_val)
  );

  pit_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .cfg_pulse(cfg_strobe),
    .load_pulse(load_pulse), .period_mode(rate_mode), .reload_val(reload_val),
    .count_q(cur_count), .running(running), .tmr_out(tmr_out)
  );

  pit_latch_rd #(.BYTE_W(BYTE_W)) u_rd (
    .clk(clk), .rst(rst), .cfg_pulse(cfg_strobe), .latch_req(latch_req),
    .rd_pulse(rd_pulse), .acc_mode(acc_mode), .count_q(cur_count),
    .held(latch_held), .snap(snap), .rdata(rdata)
  );
endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rst,
  input logic              cnt_en,
  input logic              rd_en,
  input logic              port_sel,
  input logic              tmr_out,
  input logic [BYTE_W-1:0] rdata,
  input logic [CNT_W-1:0]  cur_count,
  input logic [CNT_W-1:0]  snap,
  input logic              running,
  input logic              rate_mode,
  input logic              latch_held,
  input logic              cfg_strobe,
  input logic              load_pulse
);
  // R4
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!running && !load_pulse) |=> $stable(cur_count));

  // R4
  step_down_chk: assert property (@(posedge clk) disable iff (rst)
    (running && cnt_en && !load_pulse && !cfg_strobe && !rate_mode)
      |=> (cur_count == CNT_W'($past(cur_count) - CNT_W'(1))));

  // R5
  oneshot_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (!rate_mode && tmr_out && !cfg_strobe && !load_pulse) |=> tmr_out);

  // R6
  period_low_chk: assert property (@(posedge clk) disable iff (rst)
    (rate_mode && !tmr_out && !cfg_strobe) |-> (cur_count == CNT_W'(1)));

  // R8
  snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (latch_held && !(rd_en && !port_sel) && !cfg_strobe)
      |=> (latch_held && $stable(snap)));

  // R12
  rdata_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && !port_sel) |=> $stable(rdata));
endmodule

bind pit_channel pit_channel_chk u_chk (
  .clk(clk), .rst(rst), .cnt_en(cnt_en), .rd_en(rd_en), .port_sel(port_sel),
  .tmr_out(tmr_out), .rdata(rdata), .cur_count(cur_count), .snap(snap),
  .running(running), .rate_mode(rate_mode), .latch_held(latch_held),
  .cfg_strobe(cfg_strobe), .load_pulse(load_pulse)
);

// File: tb/sim_pit_channel.sv
module sim_pit_channel;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cnt_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0, port_sel = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       tmr_out;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  reported = 1'b0;

  always #4 clk = ~clk;

  pit_channel u0 (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .wr_en(wr_en), .rd_en(rd_en),
    .port_sel(port_sel), .wdata(wdata), .rdata(rdata), .tmr_out(tmr_out)
  );

  // periodic mode, reload 4: {expected output, expected count} after each pulse
  localparam logic [16:0] RATE_TBL [8] = '{
    {1'b1, 16'd3}, {1'b1, 16'd2}, {1'b0, 16'd1}, {1'b1, 16'd4},
    {1'b1, 16'd3}, {1'b1, 16'd2}, {1'b0, 16'd1}, {1'b1, 16'd4}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] b);
    @(negedge clk);
    port_sel = sel; wdata = b; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(output logic [7:0] b);
    @(negedge clk);
    port_sel = 1'b0; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    b = rdata;
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(lo);
    rd(hi);
    v = {hi, lo};
  endtask

  task automatic latch16(output logic [15:0] v);
    wr(1'b1, 8'h00);
    rd16(v);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cnt_en = 1'b1;
      @(negedge clk);
      cnt_en = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  b;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    chk("R11 out after reset", tmr_out, 1);
    chk("R11 rdata after reset", rdata, 0);
    latch16(v);
    chk("R11 count after reset", v, 16'h0000);

    // R5 one-shot, word transfer
    wr(1'b1, 8'h30);
    chk("R5 out low after control", tmr_out, 0);
    wr(1'b0, 8'h05); wr(1'b0, 8'h00);
    latch16(v);
    chk("R2 R7 word load readback", v, 16'h0005);
    tick(4);
    chk("R5 out low before zero", tmr_out, 0);
    latch16(v);
    chk("R4 count after four pulses", v, 16'h0001);
    tick(1);
    chk("R5 out rises at zero", tmr_out, 1);
    tick(1);
    chk("R5 out stays high", tmr_out, 1);
    latch16(v);
    chk("R5 wrap to ffff", v, 16'hFFFF);

    // R4 frozen until reload complete
    wr(1'b1, 8'h30);
    wr(1'b0, 8'h10);
    tick(3);
    latch16(v);
    chk("R4 frozen after low byte", v, 16'hFFFF);
    wr(1'b0, 8'h00);
    latch16(v);
    chk("R4 loaded after high byte", v, 16'h0010);
    tick(2);
    latch16(v);
    chk("R4 counts after load", v, 16'h000E);

    // R2 byte pointer reset by control word
    wr(1'b1, 8'h30);
    wr(1'b0, 8'h22);
    wr(1'b1, 8'h30);
    wr(1'b0, 8'h08); wr(1'b0, 8'h00);
    latch16(v);
    chk("R2 pointer reset", v, 16'h0008);

    // R6 periodic mode, table walk
    wr(1'b1, 8'h34);
    chk("R6 out high after control", tmr_out, 1);
    wr(1'b0, 8'h04); wr(1'b0, 8'h00);
    for (int i = 0; i < 8; i++) begin
      tick(1);
      chk("R6 periodic out", tmr_out, RATE_TBL[i][16]);
      latch16(v);
      chk("R6 periodic count", v, RATE_TBL[i][15:0]);
    end

    // R8 second latch ignored while held
    wr(1'b1, 8'h00);
    tick(2);
    wr(1'b1, 8'h00);
    rd16(v);
    chk("R8 older snapshot kept", v, 16'h0004);
    latch16(v);
    chk("R7 release then new latch", v, 16'h0002);

    // R9 latch coinciding with count pulse
    @(negedge clk);
    port_sel = 1'b1; wdata = 8'h00; wr_en = 1'b1; cnt_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; cnt_en = 1'b0;
    rd16(v);
    chk("R9 pre-decrement snapshot", v, 16'h0002);
    chk("R9 out low at one", tmr_out, 0);
    latch16(v);
    chk("R9 counting continued", v, 16'h0001);

    // R10 live reads, R12 registered read data
    tick(1);
    @(negedge clk);
    port_sel = 1'b0; rd_en = 1'b1;
    #1;
    chk("R12 rdata before edge", rdata, 8'h00);
    @(negedge clk);
    rd_en = 1'b0;
    chk("R10 live low byte", rdata, 8'h04);
    rd(b);
    chk("R10 live high byte", b, 8'h00);
    tick(1);
    rd16(v);
    chk("R10 live after pulse", v, 16'h0003);

    // R1 ignored control words
    wr(1'b1, 8'hC0);
    wr(1'b1, 8'h40);
    wr(1'b1, 8'h35);
    wr(1'b1, 8'h36);
    wr(1'b1, 8'h30 | 8'h0C);
    tick(1);
    chk("R1 out unchanged", tmr_out, 1);
    latch16(v);
    chk("R1 count still running", v, 16'h0002);
    tick(1);
    chk("R1 periodic mode kept", tmr_out, 0);

    // R3 single-byte transfers
    wr(1'b1, 8'h14);
    wr(1'b0, 8'h07);
    wr(1'b1, 8'h00);
    rd(b);
    chk("R3 low-only readback", b, 8'h07);
    tick(1);
    wr(1'b1, 8'h00);
    rd(b);
    chk("R3 latch freed after one read", b, 8'h06);
    wr(1'b1, 8'h20);
    wr(1'b0, 8'h02);
    rd(b);
    chk("R3 high-only live read", b, 8'h02);
    tick(1);
    wr(1'b1, 8'h00);
    rd(b);
    chk("R3 high byte after pulse", b, 8'h01);
    chk("R5 high-only one-shot out", tmr_out, 0);

    report();
  end
endmodule